// File: doc/BRIEF.md
# Posted-Write Ordering Bridge Controller

This block connects a host-side bus to an older peripheral bus of the ISA kind. Host writes aimed at the peripheral side are accepted into a small posted-write queue right away. They then leave the queue one at a time, in arrival order, through a target port that the peripheral side can stall with a busy signal. A host read aimed at the peripheral side is held as a single pending request. It goes out on the target port only once the queue is empty. Its data comes back to the host on a completion strobe. Writes posted after the read may still enter the queue, and they drain ahead of it.

A master on the peripheral bus cannot be told to retry. It can only be held with wait states. For that reason the controller grants the peripheral bus to a requesting master only when the posted-write queue is empty and no host read is pending. Host posting is stalled from the moment the master asks, so the queue is sure to drain. While the master is granted, its reads of host memory pass through a dedicated channel. The wait-state output is held for the whole time such a read is outstanding. If no master ever asks for the bus, the block is a plain in-order write buffer in front of the target port.

Top module: `pw_order_bridge`

## Requirements
- R1: After reset the queue is empty (`hp_ready` high), `lm_gnt` is low, `lm_wait` is low, `lt_req` is low and `hc_valid` is low.
- R2: Posted writes appear on the target port (`lt_req` high, `lt_we` = 1) strictly in acceptance order. A transfer completes in a cycle where `lt_req` is high and `lt_busy` is low. While `lt_busy` is high, the presented address, data and direction stay stable.
- R3: The queue holds DEPTH entries. With DEPTH writes waiting, `hp_ready` is low and no further write is taken.
- R4: A host read (accepted when `hr_valid` and `hr_ready` are both high) goes out on the target port with `lt_we` = 0 only after every write accepted before it has completed. `hr_ready` is low while a read is pending.
- R5: `hc_valid` pulses for one cycle in the cycle after the target read transfer completes. `hc_data` carries the `lt_rdata` sampled in that transfer.
- R6: A pending host read does not stop write posting. Writes accepted while the read waits are delivered before it.
- R7: `lm_gnt` rises only when the queue is empty and no host read is pending. It rises in the cycle after that condition holds together with `lm_req`.
- R8: While `lm_req` is high and the bus is not yet granted, `hp_ready` is low.
- R9: While `lm_gnt` is high, `lt_req` stays low.
- R10: A master read (`lm_rd` high while granted and `lm_wait` low) raises `lm_wait` and `mem_rd_req` in the next cycle. `mem_rd_req` stays high until `mem_rd_valid`. In the following cycle `lm_rvalid` pulses and `lm_rdata` holds `mem_rd_data`, with `lm_wait` still high. One cycle later `lm_wait` is low.
- R11: `lm_gnt` falls in the cycle after `lm_req` goes low. `hp_ready` returns high in that same following cycle, provided the queue is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hp_valid | input | 1 | Host write post valid |
| hp_ready | output | 1 | Host write post accepted when high |
| hp_addr | input | AW | Host write address |
| hp_data | input | DW | Host write data |
| hr_valid | input | 1 | Host read request valid |
| hr_ready | output | 1 | Host read request accepted when high |
| hr_addr | input | AW | Host read address |
| hc_valid | output | 1 | Host read completion strobe |
| hc_data | output | DW | Host read completion data |
| lt_req | output | 1 | Target port transfer request |
| lt_we | output | 1 | Target transfer direction, 1 = write |
| lt_addr | output | AW | Target transfer address |
| lt_wdata | output | DW | Target write data |
| lt_busy | input | 1 | Target stall; transfer completes when low |
| lt_rdata | input | DW | Target read data |
| lm_req | input | 1 | Peripheral master bus request |
| lm_gnt | output | 1 | Peripheral master bus grant |
| lm_rd | input | 1 | Master host-memory read strobe |
| lm_addr | input | AW | Master host-memory read address |
| lm_wait | output | 1 | Wait-state output to the master |
| lm_rvalid | output | 1 | Master read data strobe |
| lm_rdata | output | DW | Master read data |
| mem_rd_req | output | 1 | Host-memory read request |
| mem_rd_addr | output | AW | Host-memory read address |
| mem_rd_valid | input | 1 | Host-memory read data valid |
| mem_rd_data | input | DW | Host-memory read data |

## Verification
The bench builds the block with DEPTH = 4, AW = 8 and DW = 8. With a queue that shallow, four posts made while the target is held busy reach the full condition. Byte-wide fields let the target model return the inverted address as read data, so every completion can be matched to its own request. With a shallow queue, the flush that comes before a grant, and writes slipping past a stalled read, both happen within a few cycles. That leaves the exact cycle of each grant and completion easy to pin down.

// File: rtl/pwo_pkg.sv
package pwo_pkg;
    // Operation presented on the legacy target port
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } lt_op_e;
endpackage

// File: rtl/pwo_post_fifo.sv
module pwo_post_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTRW-1:0]             wr;
        logic [PTRW-1:0]             rd;
        logic [CNTW-1:0]             cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
        return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr           = bump(st_q.wr);
        end
        if (pop) begin
            st_d.rd = bump(st_q.rd);
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = st_q.mem[st_q.rd];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CNTW'(DEPTH));
    assign count = st_q.cnt;
endmodule

// File: rtl/pwo_master_read.sv
module pwo_master_read #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          granted,
    input  logic          lm_rd,
    input  logic [AW-1:0] lm_addr,
    output logic          lm_wait,
    output logic          lm_rvalid,
    output logic [DW-1:0] lm_rdata,
    output logic          mem_rd_req,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_valid,
    input  logic [DW-1:0] mem_rd_data
);
    typedef struct packed {
        logic          wait_st;
        logic          pend;
        logic          release_st;
        logic [AW-1:0] addr;
        logic          rvalid;
        logic [DW-1:0] rdata;
    } mrd_st_t;

    mrd_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        if (granted && lm_rd && !st_q.wait_st) begin
            st_d.wait_st = 1'b1;
            st_d.pend    = 1'b1;
            st_d.addr    = lm_addr;
        end
        if (st_q.pend && mem_rd_valid) begin
            st_d.pend       = 1'b0;
            st_d.rvalid     = 1'b1;
            st_d.rdata      = mem_rd_data;
            st_d.release_st = 1'b1;
        end
        if (st_q.release_st) begin
            st_d.wait_st    = 1'b0;
            st_d.release_st = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lm_wait     = st_q.wait_st;
    assign lm_rvalid   = st_q.rvalid;
    assign lm_rdata    = st_q.rdata;
    assign mem_rd_req  = st_q.pend;
    assign mem_rd_addr = st_q.addr;
endmodule

// File: rtl/pw_order_bridge.sv
module pw_order_bridge
    import pwo_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hp_valid,
    output logic          hp_ready,
    input  logic [AW-1:0] hp_addr,
    input  logic [DW-1:0] hp_data,
    input  logic          hr_valid,
    output logic          hr_ready,
    input  logic [AW-1:0] hr_addr,
    output logic          hc_valid,
    output logic [DW-1:0] hc_data,
    output logic          lt_req,
    output logic          lt_we,
    output logic [AW-1:0] lt_addr,
    output logic [DW-1:0] lt_wdata,
    input  logic          lt_busy,
    input  logic [DW-1:0] lt_rdata,
    input  logic          lm_req,
    output logic          lm_gnt,
    input  logic          lm_rd,
    input  logic [AW-1:0] lm_addr,
    output logic          lm_wait,
    output logic          lm_rvalid,
    output logic [DW-1:0] lm_rdata,
    output logic          mem_rd_req,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_valid,
    input  logic [DW-1:0] mem_rd_data
);
    localparam int EW   = AW + DW;
    localparam int CNTW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic          gnt;
        logic          rd_pend;
        logic          rd_go;
        logic [AW-1:0] rd_addr;
        logic          hc_valid;
        logic [DW-1:0] hc_data;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic            q_empty, q_full, q_push, q_pop;
    logic [EW-1:0]   q_head;
    logic [CNTW-1:0] q_count;
    lt_op_e          op;
    logic            xfer_done;

    // Post acceptance: stalled when full, while a master waits, or while granted
    assign hp_ready = !q_full && !lm_req && !st_q.gnt;
    assign q_push   = hp_valid && hp_ready;
    assign hr_ready = !st_q.rd_pend;

    pwo_post_fifo #(
        .DEPTH (DEPTH),
        .WIDTH (EW)
    ) post_q_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data ({hp_addr, hp_data}),
        .pop       (q_pop),
        .head      (q_head),
        .empty     (q_empty),
        .full      (q_full),
        .count     (q_count)
    );

    // Target port selection: started read sticks, writes go before a waiting read
    always_comb begin
        if (st_q.gnt)             op = OP_IDLE;
        else if (st_q.rd_go)      op = OP_READ;
        else if (!q_empty)        op = OP_WRITE;
        else if (st_q.rd_pend)    op = OP_READ;
        else                      op = OP_IDLE;
    end

    assign lt_req    = (op != OP_IDLE);
    assign lt_we     = (op == OP_WRITE);
    assign lt_addr   = (op == OP_WRITE) ? q_head[EW-1:DW] : st_q.rd_addr;
    assign lt_wdata  = (op == OP_WRITE) ? q_head[DW-1:0] : '0;
    assign xfer_done = lt_req && !lt_busy;
    assign q_pop     = xfer_done && (op == OP_WRITE);

    always_comb begin
        st_d          = st_q;
        st_d.hc_valid = 1'b0;
        if (hr_valid && hr_ready) begin
            st_d.rd_pend = 1'b1;
            st_d.rd_addr = hr_addr;
        end
        if (op == OP_READ) begin
            if (lt_busy) begin
                st_d.rd_go = 1'b1;
            end else begin
                st_d.rd_go    = 1'b0;
                st_d.rd_pend  = 1'b0;
                st_d.hc_valid = 1'b1;
                st_d.hc_data  = lt_rdata;
            end
        end
        if (st_q.gnt) begin
            st_d.gnt = lm_req;
        end else begin
            st_d.gnt = lm_req && q_empty && !st_q.rd_pend;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lm_gnt   = st_q.gnt;
    assign hc_valid = st_q.hc_valid;
    assign hc_data  = st_q.hc_data;

    pwo_master_read #(
        .AW (AW),
        .DW (DW)
    ) mrd_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .granted      (st_q.gnt),
        .lm_rd        (lm_rd),
        .lm_addr      (lm_addr),
        .lm_wait      (lm_wait),
        .lm_rvalid    (lm_rvalid),
        .lm_rdata     (lm_rdata),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data)
    );
endmodule

// File: rtl/pw_order_checker.sv
module pw_order_checker #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       hp_ready,
    input logic                       lm_req,
    input logic                       lm_gnt,
    input logic                       lt_req,
    input logic                       lt_we,
    input logic                       lt_busy,
    input logic [AW-1:0]              lt_addr,
    input logic [DW-1:0]              lt_wdata,
    input logic                       hc_valid,
    input logic                       mem_rd_req,
    input logic                       lm_wait,
    input logic [$clog2(DEPTH+1)-1:0] q_count
);
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= ($clog2(DEPTH+1))'(DEPTH));

    assert_full_stalls_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == ($clog2(DEPTH+1))'(DEPTH)) |-> !hp_ready);

    assert_target_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lt_req && lt_busy) |=> (lt_req && $stable(lt_we) && $stable(lt_addr) && $stable(lt_wdata)));

    assert_gnt_needs_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lm_gnt |-> (q_count == '0));

    assert_posting_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lm_req && !lm_gnt) |-> !hp_ready);

    assert_quiet_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lm_gnt |-> !lt_req);

    assert_completion_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lt_req && !lt_we && !lt_busy) |=> hc_valid);

    assert_wait_covers_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> lm_wait);

    assert_gnt_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lm_gnt && !lm_req) |=> !lm_gnt);
endmodule

bind pw_order_bridge pw_order_checker #(
    .DEPTH (DEPTH),
    .AW    (AW),
    .DW    (DW)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hp_ready   (hp_ready),
    .lm_req     (lm_req),
    .lm_gnt     (lm_gnt),
    .lt_req     (lt_req),
    .lt_we      (lt_we),
    .lt_busy    (lt_busy),
    .lt_addr    (lt_addr),
    .lt_wdata   (lt_wdata),
    .hc_valid   (hc_valid),
    .mem_rd_req (mem_rd_req),
    .lm_wait    (lm_wait),
    .q_count    (q_count)
);

// File: tb/pw_order_bridge_tb_top.sv
module pw_order_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int NVEC = 6;
    // each vector: {address, data}
    localparam logic [15:0] VEC [NVEC] = '{16'h1A01, 16'h2B02, 16'h3C03,
                                            16'h4D04, 16'h5E05, 16'h6F06};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hp_valid = 1'b0, hr_valid = 1'b0, lm_req = 1'b0, lm_rd = 1'b0, mem_rd_valid = 1'b0;
    logic [AW-1:0] hp_addr = '0, hr_addr = '0, lm_addr = '0;
    logic [DW-1:0] hp_data = '0, mem_rd_data = '0;
    logic hp_ready, hr_ready, hc_valid, lt_req, lt_we, lt_busy, lm_gnt, lm_wait, lm_rvalid, mem_rd_req;
    logic [DW-1:0] hc_data, lt_wdata, lt_rdata, lm_rdata;
    logic [AW-1:0] lt_addr, mem_rd_addr;
    logic hold_busy = 1'b0, pat_en = 1'b0;
    int cyc_cnt = 0;

    int n_checks = 0, n_errors = 0;
    int log_n = 0, hc_n = 0, hc_cyc = 0;
    logic [DW-1:0] hc_last = '0;
    logic          log_we   [64];
    logic [AW-1:0] log_addr [64];
    logic [DW-1:0] log_data [64];
    int            log_cyc  [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    // target model: stalls on demand, returns inverted address as read data
    assign lt_busy  = hold_busy | (pat_en & cyc_cnt[0]);
    assign lt_rdata = ~lt_addr;

    pw_order_bridge #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .hp_valid(hp_valid), .hp_ready(hp_ready), .hp_addr(hp_addr), .hp_data(hp_data),
        .hr_valid(hr_valid), .hr_ready(hr_ready), .hr_addr(hr_addr),
        .hc_valid(hc_valid), .hc_data(hc_data),
        .lt_req(lt_req), .lt_we(lt_we), .lt_addr(lt_addr), .lt_wdata(lt_wdata),
        .lt_busy(lt_busy), .lt_rdata(lt_rdata),
        .lm_req(lm_req), .lm_gnt(lm_gnt), .lm_rd(lm_rd), .lm_addr(lm_addr),
        .lm_wait(lm_wait), .lm_rvalid(lm_rvalid), .lm_rdata(lm_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
    );

    // monitor: pre-edge values at each rising edge
    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (rst_n && lt_req && !lt_busy && log_n < 64) begin
            log_we[log_n]   = lt_we;
            log_addr[log_n] = lt_addr;
            log_data[log_n] = lt_wdata;
            log_cyc[log_n]  = cyc_cnt;
            log_n           = log_n + 1;
        end
        if (rst_n && hc_valid) begin
            hc_n    = hc_n + 1;
            hc_cyc  = cyc_cnt;
            hc_last = hc_data;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic post(input logic [AW-1:0] a, input logic [DW-1:0] d);
        hp_valid = 1'b1; hp_addr = a; hp_data = d;
        for (int k = 0; k < 500; k++) begin
            if (hp_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        hp_valid = 1'b0;
    endtask

    task automatic wait_log(input int n);
        for (int k = 0; k < 500 && log_n < n; k++) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 hp_ready", 32'(hp_ready), 1);
        check("R1 lm_gnt", 32'(lm_gnt), 0);
        check("R1 lm_wait", 32'(lm_wait), 0);
        check("R1 lt_req", 32'(lt_req), 0);
        check("R1 hc_valid", 32'(hc_valid), 0);

        // R2: vector table, target stalling every other cycle
        pat_en = 1'b1;
        for (int i = 0; i < NVEC; i++) post(VEC[i][15:8], VEC[i][7:0]);
        wait_log(NVEC);
        for (int i = 0; i < NVEC; i++) begin
            check("R2 order addr", 32'(log_addr[i]), 32'(VEC[i][15:8]));
            check("R2 order data", 32'(log_data[i]), 32'(VEC[i][7:0]));
            check("R2 write dir", 32'(log_we[i]), 1);
        end
        pat_en = 1'b0;

        // R3: fill queue while target busy
        base = log_n;
        hold_busy = 1'b1;
        for (int i = 0; i < DEPTH; i++) post(AW'(8'h80 + i), DW'(8'hC0 + i));
        check("R3 hp_ready low when full", 32'(hp_ready), 0);
        check("R2 head held while busy", 32'(lt_addr), 32'h80);
        hold_busy = 1'b0;
        wait_log(base + DEPTH);
        for (int i = 0; i < DEPTH; i++)
            check("R3 drained order", 32'(log_addr[base+i]), 32'h80 + 32'(i));

        // R4 R5 R6: read pushes earlier writes; later writes pass it
        base = log_n;
        hold_busy = 1'b1;
        post(8'h40, 8'h01);
        post(8'h41, 8'h02);
        hr_valid = 1'b1; hr_addr = 8'h77;
        @(negedge clk);
        hr_valid = 1'b0;
        check("R4 hr_ready low while pending", 32'(hr_ready), 0);
        check("R6 posting open with read pending", 32'(hp_ready), 1);
        post(8'h42, 8'h03);
        check("R4 write still presented", 32'(lt_we), 1);
        hold_busy = 1'b0;
        for (int k = 0; k < 500 && hc_n < 1; k++) @(negedge clk);
        check("R4 write A first", 32'(log_addr[base]), 32'h40);
        check("R4 write B second", 32'(log_addr[base+1]), 32'h41);
        check("R6 later write passes read", 32'(log_addr[base+2]), 32'h42);
        check("R4 read direction", 32'(log_we[base+3]), 0);
        check("R4 read address", 32'(log_addr[base+3]), 32'h77);
        check("R5 completion data", 32'(hc_last), 32'h88);
        check("R5 completion cycle", 32'(hc_cyc), 32'(log_cyc[base+3] + 1));
        check("R5 single pulse", 32'(hc_n), 1);

        // R7 R8 R9: flush before grant
        base = log_n;
        hold_busy = 1'b1;
        post(8'h50, 8'h11);
        post(8'h51, 8'h12);
        lm_req = 1'b1;
        @(negedge clk);
        check("R7 no grant with queue busy", 32'(lm_gnt), 0);
        check("R8 posting held during flush", 32'(hp_ready), 0);
        repeat (3) @(negedge clk);
        check("R7 still withheld", 32'(lm_gnt), 0);
        hold_busy = 1'b0;
        for (int k = 0; k < 500 && !lm_gnt; k++) @(negedge clk);
        check("R7 grant arrives", 32'(lm_gnt), 1);
        check("R7 queue drained at grant", 32'(log_n), 32'(base + 2));
        check("R7 grant one cycle after drain", 32'(cyc_cnt), 32'(log_cyc[base+1] + 2));
        check("R9 target quiet", 32'(lt_req), 0);

        // R10: master read of host memory
        lm_rd = 1'b1; lm_addr = 8'h3E;
        @(negedge clk);
        lm_rd = 1'b0;
        check("R10 wait raised", 32'(lm_wait), 1);
        check("R10 mem request", 32'(mem_rd_req), 1);
        check("R10 mem address", 32'(mem_rd_addr), 32'h3E);
        repeat (3) @(negedge clk);
        check("R10 wait held", 32'(lm_wait), 1);
        check("R9 target quiet while granted", 32'(lt_req), 0);
        mem_rd_valid = 1'b1; mem_rd_data = 8'hA5;
        @(negedge clk);
        mem_rd_valid = 1'b0;
        check("R10 rvalid", 32'(lm_rvalid), 1);
        check("R10 rdata", 32'(lm_rdata), 32'hA5);
        check("R10 wait during data", 32'(lm_wait), 1);
        check("R10 mem request dropped", 32'(mem_rd_req), 0);
        @(negedge clk);
        check("R10 wait released", 32'(lm_wait), 0);
        check("R10 rvalid pulse ends", 32'(lm_rvalid), 0);

        // R11: release
        lm_req = 1'b0;
        check("R11 grant still high", 32'(lm_gnt), 1);
        check("R11 posting still closed", 32'(hp_ready), 0);
        @(negedge clk);
        check("R11 grant dropped", 32'(lm_gnt), 0);
        check("R11 posting resumes", 32'(hp_ready), 1);
        base = log_n;
        post(8'h60, 8'h21);
        wait_log(base + 1);
        check("R11 write drains after release", 32'(log_addr[base]), 32'h60);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule